// File: doc/BRIEF.md
# Oscillator Warm-up and Clock Source Switchover Controller

This block decides which clock the core runs from after a power-on reset, after any other reset, and when the chip leaves its low-power stop state. On each of these events it restarts a warm-up count of crystal tick-enable pulses. When the count completes it raises a clock-ready flag. The flag also drops, and the count restarts, when the clock multiplier is switched on. While the flag is low, the two-bit clock-divide field cannot be changed. The multiplier is only reported as the selected source once the flag is high.

During warm-up the core either waits, with core-hold asserted, or runs from the internal ring oscillator. A ring-select bit chooses between the two. The ring-select bit and the ring-mode status survive every reset except power-on. When warm-up completes, the source moves to the crystal and core-hold is released on the same clock edge. A stop-mode reference-enable bit sits beside these. It only changes through a two-key unlock sequence followed by a short write window.

Top module: `osc_warmup_ctrl`

## Requirements
- R1: After a power-on reset the block shows clkReady=0, srcRing=0, coreHold=1, bgStopEn=1 and divSel=0, and ring select reads 0.
- R2: clkReady clears on the edge that sees any reset, a stopExit pulse, or a 0-to-1 change of mulEn. It is set on the edge that takes the 2^CNT_W-th xtalTick pulse counted since the clear (65,536 at the default).
- R3: A write to address 1 loads regWdata[1:0] into divSel only when clkReady is 1. While clkReady is 0 the write has no effect.
- R4: mulSel is 1 exactly when mulEn is 1 and clkReady is 1.
- R5: A stop exit or a non-power-on reset loads srcRing from the ring-select bit. srcRing returns to 0 on the edge that sets clkReady. A non-power-on reset leaves the ring-select bit unchanged.
- R6: A stop exit or reset with ring select 0 asserts coreHold. coreHold deasserts on the edge that sets clkReady, and it is never 1 while srcRing is 1.
- R7: A write to address 0 always loads ring select from bit 1. It loads bgStopEn from bit 0 only while the unlock window is open. Any reset sets bgStopEn to 1.
- R8: Writing 0xAA and then 0x55 to address 2 opens the unlock window for the 4 cycles that follow. A write to address 0 closes the window. Any other write between the two keys cancels the unlock.
- R9: A read of address 0 returns {0000, clkReady, srcRing, ring select, bgStopEn} in bits 7:0. A read of address 1 returns divSel in bits 1:0. All other addresses and bits read 0.
- R10: A stopExit arriving on the same cycle as the final warm-up tick wins, so clkReady stays 0 and the count starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porRst | input | 1 | Power-on reset, synchronous, active high |
| sysRst | input | 1 | Any other reset, synchronous, active high |
| stopExit | input | 1 | One-cycle pulse on leaving stop state |
| mulEn | input | 1 | Clock multiplier enable level |
| xtalTick | input | 1 | Crystal tick enable, one per counted crystal clock |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | DW | Register write data |
| regRdata | output | DW | Register read data, combinational on regAddr |
| clkReady | output | 1 | Warm-up complete flag |
| srcRing | output | 1 | 1 = core clock from ring oscillator, 0 = crystal |
| coreHold | output | 1 | Holds the core during warm-up |
| mulSel | output | 1 | Multiplier selected as clock source |
| divSel | output | 2 | Clock-divide field |
| bgStopEn | output | 1 | Reference kept on during stop |

## Verification
The hardest case to reach is a restart that lands exactly on the last warm-up tick. Without tight counting it shows up as a one-cycle early or late ready flag. The bench counts out one tick fewer than the terminal value after a stop exit, then drives the final tick and a new stopExit in the same cycle. The unlock window edges are reached the same way: the protected write is placed on the fourth cycle after the second key, then on the fifth. A reference model compares every output on every cycle, so an off-by-one in any of these shows up at once.

// File: rtl/osc_warmup_pkg.sv
package osc_warmup_pkg;

  localparam int REG_AW = 2;

  localparam logic [REG_AW-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_DIV    = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_UNLOCK = 2'd2;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;

  typedef enum logic [1:0] {
    TA_IDLE  = 2'd0,
    TA_ARMED = 2'd1,
    TA_OPEN  = 2'd2
  } taState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic warmRestart;  // restart the warm-up count (stop exit or multiplier rise)
    logic srcReload;    // reload the clock source from ring select
    logic ringSelWr;    // load ring select
    logic bgWr;         // load stop-mode reference enable
    logic divWr;        // load clock-divide field
  } ctlStrobe_t;

endpackage

// File: rtl/osc_warmup_ctl.sv
module osc_warmup_ctl
  import osc_warmup_pkg::*;
#(
  parameter int DW      = 8,
  parameter int WIN_LEN = 4
) (
  input  logic              clk,
  input  logic              porRst,
  input  logic              sysRst,
  input  logic              stopExit,
  input  logic              mulEn,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DW-1:0]     regWdata,
  input  logic              warmReady,
  output ctlStrobe_t        strobe
);

  localparam int WIN_W = $clog2(WIN_LEN + 1);

  taState_e         taQ;
  logic [WIN_W-1:0] winQ;
  logic             mulEnQ;
  logic             anyRst;
  logic             mulRise;
  logic             wrCtrl;
  logic             wrDiv;
  logic             wrUnlock;
  logic             keyFirst;
  logic             keySecond;

  always_comb begin
    anyRst    = porRst | sysRst;
    mulRise   = mulEn & ~mulEnQ;
    wrCtrl    = regWe && (regAddr == ADDR_CTRL);
    wrDiv     = regWe && (regAddr == ADDR_DIV);
    wrUnlock  = regWe && (regAddr == ADDR_UNLOCK);
    keyFirst  = (regWdata[7:0] == KEY_FIRST);
    keySecond = (regWdata[7:0] == KEY_SECOND);

    strobe.warmRestart = stopExit | mulRise;
    strobe.srcReload   = stopExit;
    strobe.ringSelWr   = wrCtrl;
    strobe.bgWr        = wrCtrl && (taQ == TA_OPEN);
    strobe.divWr       = wrDiv && warmReady;
  end

  always_ff @(posedge clk) begin
    if (anyRst) begin
      taQ    <= TA_IDLE;
      winQ   <= '0;
      mulEnQ <= mulEn;
    end else begin
      mulEnQ <= mulEn;
      if (wrUnlock) begin
        if (keyFirst) begin
          taQ <= TA_ARMED;
        end else if (keySecond && (taQ == TA_ARMED)) begin
          taQ  <= TA_OPEN;
          winQ <= WIN_W'(WIN_LEN);
        end else begin
          taQ <= TA_IDLE;
        end
      end else if ((taQ == TA_ARMED) && regWe) begin
        taQ <= TA_IDLE;
      end else if (taQ == TA_OPEN) begin
        if (wrCtrl || (winQ == WIN_W'(1))) begin
          taQ <= TA_IDLE;
        end else begin
          winQ <= winQ - WIN_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/osc_warmup_dp.sv
module osc_warmup_dp
  import osc_warmup_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DW    = 8
) (
  input  logic              clk,
  input  logic              porRst,
  input  logic              sysRst,
  input  logic              xtalTick,
  input  ctlStrobe_t        strobe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [1:0]        wrLow,
  output logic              warmReady,
  output logic              ringStat,
  output logic              holdCore,
  output logic              bgEn,
  output logic [1:0]        divQ,
  output logic [DW-1:0]     regRdata
);

  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  logic [CNT_W-1:0] cntQ;
  logic             ringSelQ;
  logic             finalTick;

  assign finalTick = xtalTick && !warmReady && (cntQ == CNT_LAST);

  always_ff @(posedge clk) begin
    if (porRst) begin
      cntQ      <= '0;
      warmReady <= 1'b0;
      ringStat  <= 1'b0;
      holdCore  <= 1'b1;
      ringSelQ  <= 1'b0;
      bgEn      <= 1'b1;
      divQ      <= 2'd0;
    end else if (sysRst) begin
      cntQ      <= '0;
      warmReady <= 1'b0;
      ringStat  <= ringSelQ;
      holdCore  <= ~ringSelQ;
      bgEn      <= 1'b1;
      divQ      <= 2'd0;
    end else begin
      if (strobe.ringSelWr) ringSelQ <= wrLow[1];
      if (strobe.bgWr)      bgEn     <= wrLow[0];
      if (strobe.divWr)     divQ     <= wrLow;
      if (strobe.warmRestart) begin
        cntQ      <= '0;
        warmReady <= 1'b0;
        if (strobe.srcReload) begin
          ringStat <= ringSelQ;
          holdCore <= ~ringSelQ;
        end
      end else if (finalTick) begin
        cntQ      <= '0;
        warmReady <= 1'b1;
        ringStat  <= 1'b0;
        holdCore  <= 1'b0;
      end else if (xtalTick && !warmReady) begin
        cntQ <= cntQ + CNT_W'(1);
      end
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_CTRL: regRdata[3:0] = {warmReady, ringStat, ringSelQ, bgEn};
      ADDR_DIV:  regRdata[1:0] = divQ;
      default:   regRdata = '0;
    endcase
  end

endmodule

// File: rtl/osc_warmup_ctrl.sv
module osc_warmup_ctrl
  import osc_warmup_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int WIN_LEN = 4,
  parameter int DW      = 8
) (
  input  logic              clk,
  input  logic              porRst,
  input  logic              sysRst,
  input  logic              stopExit,
  input  logic              mulEn,
  input  logic              xtalTick,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DW-1:0]     regWdata,
  output logic [DW-1:0]     regRdata,
  output logic              clkReady,
  output logic              srcRing,
  output logic              coreHold,
  output logic              mulSel,
  output logic [1:0]        divSel,
  output logic              bgStopEn
);

  ctlStrobe_t strobe;
  logic       warmReady;

  osc_warmup_ctl #(
    .DW      (DW),
    .WIN_LEN (WIN_LEN)
  ) uCtl (
    .clk       (clk),
    .porRst    (porRst),
    .sysRst    (sysRst),
    .stopExit  (stopExit),
    .mulEn     (mulEn),
    .regWe     (regWe),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .warmReady (warmReady),
    .strobe    (strobe)
  );

  osc_warmup_dp #(
    .CNT_W (CNT_W),
    .DW    (DW)
  ) uDp (
    .clk       (clk),
    .porRst    (porRst),
    .sysRst    (sysRst),
    .xtalTick  (xtalTick),
    .strobe    (strobe),
    .regAddr   (regAddr),
    .wrLow     (regWdata[1:0]),
    .warmReady (warmReady),
    .ringStat  (srcRing),
    .holdCore  (coreHold),
    .bgEn      (bgStopEn),
    .divQ      (divSel),
    .regRdata  (regRdata)
  );

  assign clkReady = warmReady;
  assign mulSel   = mulEn & warmReady;

endmodule

// File: rtl/osc_warmup_chk.sv
module osc_warmup_chk (
  input logic       clk,
  input logic       porRst,
  input logic       sysRst,
  input logic       stopExit,
  input logic       mulEn,
  input logic       regWe,
  input logic [1:0] regAddr,
  input logic       clkReady,
  input logic       srcRing,
  input logic       coreHold,
  input logic       mulSel,
  input logic [1:0] divSel,
  input logic       bgStopEn
);

  logic anyRst;
  assign anyRst = porRst | sysRst;

  AST_POR_STATE: assert property (@(posedge clk) disable iff (porRst)
    $past(porRst) |-> (!clkReady && !srcRing && coreHold && bgStopEn && (divSel == 2'd0))); // R1

  AST_STOP_CLEARS_READY: assert property (@(posedge clk) disable iff (anyRst)
    stopExit |=> !clkReady); // R2

  AST_MUL_RISE_CLEARS_READY: assert property (@(posedge clk) disable iff (anyRst)
    $rose(mulEn) |=> !clkReady); // R2

  AST_DIV_LOCKED: assert property (@(posedge clk) disable iff (anyRst)
    !clkReady |=> $stable(divSel)); // R3

  AST_MUL_NEEDS_READY: assert property (@(posedge clk) disable iff (anyRst)
    mulSel |-> clkReady); // R4

  AST_SRC_HANDOVER: assert property (@(posedge clk) disable iff (anyRst)
    $rose(clkReady) |-> !srcRing); // R5

  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (anyRst)
    $rose(clkReady) |-> !coreHold); // R6

  AST_HOLD_NOT_RING: assert property (@(posedge clk) disable iff (anyRst)
    coreHold |-> !srcRing); // R6

  AST_BG_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (anyRst)
    !(regWe && (regAddr == 2'd0)) |=> $stable(bgStopEn)); // R7

endmodule

bind osc_warmup_ctrl osc_warmup_chk uChk (
  .clk      (clk),
  .porRst   (porRst),
  .sysRst   (sysRst),
  .stopExit (stopExit),
  .mulEn    (mulEn),
  .regWe    (regWe),
  .regAddr  (regAddr),
  .clkReady (clkReady),
  .srcRing  (srcRing),
  .coreHold (coreHold),
  .mulSel   (mulSel),
  .divSel   (divSel),
  .bgStopEn (bgStopEn)
);

// File: tb/sim_osc_warmup_ctrl.sv
module sim_osc_warmup_ctrl;

  localparam int CW   = 8;
  localparam int WIN  = 4;
  localparam int DW   = 8;
  localparam int TERM = 1 << CW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       porRst   = 1'b1;
  logic       sysRst   = 1'b0;
  logic       stopExit = 1'b0;
  logic       mulEn    = 1'b0;
  logic       xtalTick = 1'b0;
  logic       regWe    = 1'b0;
  logic [1:0] regAddr  = 2'd0;
  logic [7:0] regWdata = 8'd0;

  logic [7:0] regRdata;
  logic       clkReady, srcRing, coreHold, mulSel, bgStopEn;
  logic [1:0] divSel;

  osc_warmup_ctrl #(.CNT_W(CW), .WIN_LEN(WIN), .DW(DW)) u0 (
    .clk(clk), .porRst(porRst), .sysRst(sysRst), .stopExit(stopExit),
    .mulEn(mulEn), .xtalTick(xtalTick), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .clkReady(clkReady),
    .srcRing(srcRing), .coreHold(coreHold), .mulSel(mulSel),
    .divSel(divSel), .bgStopEn(bgStopEn)
  );

  int vecCnt = 0;
  int errCnt = 0;
  bit finished = 1'b0;

  // reference model state
  int       mCnt = 0, mWin = 0, mTa = 0;
  bit       mReady = 0, mRing = 0, mHold = 1, mRingSel = 0, mBg = 1, mMulQ = 0;
  bit [1:0] mDiv = 0;

  always @(posedge clk) begin : refModel
    bit oldRingSel, oldReady, restart;
    int oldTa;
    if (porRst) begin
      mCnt = 0; mReady = 0; mRing = 0; mHold = 1; mRingSel = 0; mBg = 1;
      mDiv = 0; mMulQ = mulEn; mTa = 0; mWin = 0;
    end else if (sysRst) begin
      mCnt = 0; mReady = 0; mRing = mRingSel; mHold = !mRingSel; mBg = 1;
      mDiv = 0; mMulQ = mulEn; mTa = 0; mWin = 0;
    end else begin
      oldRingSel = mRingSel;
      oldReady   = mReady;
      oldTa      = mTa;
      restart    = stopExit || (mulEn && !mMulQ);
      mMulQ      = mulEn;
      if (regWe && regAddr == 2'd0) begin
        mRingSel = regWdata[1];
        if (oldTa == 2) mBg = regWdata[0];
      end
      if (regWe && regAddr == 2'd1 && oldReady) mDiv = regWdata[1:0];
      if (regWe && regAddr == 2'd2) begin
        if (regWdata == 8'hAA) mTa = 1;
        else if (regWdata == 8'h55 && oldTa == 1) begin mTa = 2; mWin = WIN; end
        else mTa = 0;
      end else if (oldTa == 1 && regWe) begin
        mTa = 0;
      end else if (oldTa == 2) begin
        if ((regWe && regAddr == 2'd0) || mWin == 1) mTa = 0;
        else mWin = mWin - 1;
      end
      if (restart) begin
        mCnt = 0; mReady = 0;
        if (stopExit) begin mRing = oldRingSel; mHold = !oldRingSel; end
      end else if (xtalTick && !oldReady) begin
        if (mCnt == TERM - 1) begin
          mReady = 1; mCnt = 0; mRing = 0; mHold = 0;
        end else begin
          mCnt = mCnt + 1;
        end
      end
    end
  end

  task automatic cmp1(string tag, int act, int exp);
    vecCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    logic [7:0] expRd;
    cmp1("R2 clkReady", clkReady, mReady);
    cmp1("R5 srcRing", srcRing, mRing);
    cmp1("R6 coreHold", coreHold, mHold);
    cmp1("R3 divSel", divSel, mDiv);
    cmp1("R7 bgStopEn", bgStopEn, mBg);
    cmp1("R4 mulSel", mulSel, mulEn && mReady);
    expRd = 8'd0;
    if (regAddr == 2'd0) expRd = {4'b0000, mReady, mRing, mRingSel, mBg};
    else if (regAddr == 2'd1) expRd = {6'b000000, mDiv};
    cmp1("R9 regRdata", regRdata, expRd);
  endtask

  task automatic step();
    @(negedge clk);
    checkAll();
  endtask

  task automatic idle(int n, bit tick);
    for (int i = 0; i < n; i++) begin
      xtalTick = tick;
      step();
    end
    xtalTick = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    step();
    regWe = 1'b0;
  endtask

  task automatic pulseStop();
    stopExit = 1'b1;
    step();
    stopExit = 1'b0;
  endtask

  task automatic doReset(bit por);
    if (por) porRst = 1'b1; else sysRst = 1'b1;
    step(); step();
    porRst = 1'b0; sysRst = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog actual=running expected=done");
    finish();
  end

  initial begin
    step(); step();
    // R1 reset state
    cmp1("R1 clkReady after POR", clkReady, 0);
    cmp1("R1 srcRing after POR", srcRing, 0);
    cmp1("R1 coreHold after POR", coreHold, 1);
    cmp1("R1 bgStopEn after POR", bgStopEn, 1);
    cmp1("R1 divSel after POR", divSel, 0);
    cmp1("R1 read ring select 0", regRdata, 8'h01);
    porRst = 1'b0;

    // R3 divide write locked while not ready
    wr(2'd1, 8'h03);
    cmp1("R3 divide write ignored while not ready", divSel, 0);

    // R2 half-rate ticks
    for (int i = 0; i < 2 * TERM + 4; i++) begin
      xtalTick = i[0];
      step();
    end
    xtalTick = 1'b0;
    cmp1("R2 ready after warm-up", clkReady, 1);
    cmp1("R6 hold released", coreHold, 0);

    wr(2'd1, 8'h02);
    cmp1("R3 divide write accepted when ready", divSel, 2);

    // R4 multiplier rise
    mulEn = 1'b1;
    step();
    cmp1("R2 ready cleared by multiplier rise", clkReady, 0);
    cmp1("R4 multiplier not selected yet", mulSel, 0);
    idle(TERM + 2, 1'b1);
    cmp1("R4 multiplier selected", mulSel, 1);

    // R5 ring mode via stop exit
    wr(2'd0, 8'h02);
    cmp1("R7 bg write ignored without unlock", bgStopEn, 1);
    pulseStop();
    cmp1("R5 running from ring", srcRing, 1);
    cmp1("R6 no hold in ring mode", coreHold, 0);
    regAddr = 2'd0;
    step();
    cmp1("R9 control read", regRdata, 8'h07);
    idle(TERM + 2, 1'b1);
    cmp1("R5 moved to crystal", srcRing, 0);

    // R5 non-POR reset keeps ring select
    doReset(1'b0);
    cmp1("R5 ring after system reset", srcRing, 1);
    idle(TERM + 2, 1'b1);

    // R8 timed access
    wr(2'd2, 8'hAA); wr(2'd2, 8'h55); wr(2'd0, 8'h02);
    cmp1("R8 protected write in window", bgStopEn, 0);
    wr(2'd0, 8'h03);
    cmp1("R8 window consumed", bgStopEn, 0);
    wr(2'd2, 8'hAA); wr(2'd2, 8'h55); idle(4, 1'b0); wr(2'd0, 8'h03);
    cmp1("R8 window timed out", bgStopEn, 0);
    wr(2'd2, 8'hAA); wr(2'd2, 8'h55); idle(3, 1'b0); wr(2'd0, 8'h03);
    cmp1("R8 last window cycle", bgStopEn, 1);
    wr(2'd2, 8'hAA); wr(2'd1, 8'h00); wr(2'd2, 8'h55); wr(2'd0, 8'h00);
    cmp1("R8 broken key sequence", bgStopEn, 1);

    // R6 hold mode, R10 restart on final tick
    wr(2'd0, 8'h00);
    pulseStop();
    cmp1("R6 hold during warm-up", coreHold, 1);
    cmp1("R6 crystal source while held", srcRing, 0);
    idle(TERM - 1, 1'b1);
    xtalTick = 1'b1; stopExit = 1'b1;
    step();
    xtalTick = 1'b0; stopExit = 1'b0;
    cmp1("R10 restart beats final tick", clkReady, 0);
    cmp1("R10 hold kept", coreHold, 1);
    idle(TERM, 1'b1);
    cmp1("R2 ready after exact count", clkReady, 1);

    // R9 unused address
    regAddr = 2'd3;
    step();
    cmp1("R9 unused address reads 0", regRdata, 0);

    // R1 power-on clears ring select
    wr(2'd0, 8'h02);
    doReset(1'b1);
    regAddr = 2'd0;
    step();
    cmp1("R1 ring select cleared by POR", regRdata, 8'h01);
    idle(8, 1'b1);
    finish();
  end

endmodule